// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt lines from peripherals and spreads them over a small group of CPUs, driving one level IRQ line per CPU. Software turns sources on and off by writing a source number into set/clear registers, so no read-modify-write of a bit vector is ever needed. Each source has a routing word that chooses which CPUs may see it. Each CPU also has its own mask, changed the same way through its private register window.

A CPU services its line by reading its acknowledge register. That read returns the lowest-numbered source that is pending for that CPU. Source 0 is the CPU's own doorbell summary line. Source 5 is the CPU's own private timer line, which bypasses the routing words. Because the inputs are levels, a read has no side effects. A source stays reported until its input drops or it is gated off.

Top module: `mpic_top`

## Requirements
- R1: A global-window read at offset 0x000 returns the number of implemented sources (NUM_SRC) in bits [11:2], with all other bits zero.
- R2: Writing a source number (bits [9:0] of the write data) to global offset 0x030 sets that source's global enable, and writing it to global offset 0x034 clears it. A number at or above NUM_SRC changes no enable.
- R3: The routing word of source s is at global offset 0x100 + 4*s. Bits [NUM_CPU-1:0] select the CPUs that may receive the source, and they read back as written. All other bits read as zero.
- R4: Writing a source number to per-CPU offset 0x048 masks that source for the accessing CPU only. Writing it to per-CPU offset 0x04C unmasks it for that CPU only.
- R5: A shared source s (any source other than 0 and 5) is pending for CPU c when srcLevel[s] is high, s is globally enabled, routing bit c of s is set, and s is unmasked for c.
- R6: A per-CPU read at offset 0x044 returns, in bits [9:0], the lowest-numbered source pending for the accessing CPU, or 1023 if none is pending. Bits [31:10] read as zero.
- R7: irqOut[c] is high exactly when CPU c's acknowledge value is not 1023.
- R8: Source 0 for CPU c is dbellLevel[c], gated only by c's mask bit 0. An acknowledge value of 0 therefore identifies the doorbell summary.
- R9: Source 5 for CPU c is privLevel[c], gated by the global enable of source 5 and c's mask bit 5. The routing word of source 5 is ignored, and srcLevel[0] and srcLevel[5] have no effect.
- R10: Pending state follows the input levels with no latching. Reading the acknowledge register does not clear anything, and a source stops being reported once its input drops.
- R11: A source routed to several CPUs is reported by the acknowledge register of every one of them.
- R12: After reset all global enables and routing bits are zero and every per-CPU mask bit is set, so no IRQ is raised and every acknowledge read returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe for the current bus address |
| busLocal | input | 1 | 1 selects the per-CPU window of busCpu, 0 selects the global window |
| busCpu | input | CPU_W | Number of the CPU making the access |
| busAddr | input | 12 | Byte offset within the selected window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| srcLevel | input | NUM_SRC | Shared peripheral interrupt levels |
| privLevel | input | NUM_CPU | Per-CPU private timer levels (source 5) |
| dbellLevel | input | NUM_CPU | Per-CPU doorbell summary levels (source 0) |
| irqOut | output | NUM_CPU | Level IRQ line per CPU |

## Verification
The assertions assume that at most one register write is presented per cycle and that busCpu names an implemented CPU whenever a per-CPU access is made. The bench holds busWrite for exactly one clock and only ever drives CPU numbers 0 and 1. It changes the interrupt levels and the bus inputs only on the falling clock edge, so every level is stable across the edge that samples it. Source numbers written to the set/clear registers are allowed out of range on purpose, because the enable-update assertions apply only to in-range numbers.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_W  = 10;
  localparam logic [NUM_W-1:0] ACK_NONE = 10'd1023;

  // Register offsets (byte addresses inside a window)
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_EN_SET  = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_ACK     = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_MSK_SET = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_MSK_CLR = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_ROUTE   = 12'h100;

  typedef struct packed {
    logic              enSet;
    logic              enClr;
    logic              maskSet;
    logic              maskClr;
    logic              routeWr;
    logic [NUM_W-1:0]  idx;
    logic [3:0]        cpu;
    logic [15:0]       routeVal;
  } strobe_t;
endpackage

// File: rtl/mpic_ctrl.sv
module mpic_ctrl
  import mpic_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SRC = 16,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               busWrite,
  input  logic                               busLocal,
  input  logic [CPU_W-1:0]                   busCpu,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [DATA_W-1:0]                  busWdata,
  output logic [DATA_W-1:0]                  busRdata,
  input  logic [NUM_CPU-1:0][NUM_W-1:0]      ackNum,
  input  logic [NUM_SRC-1:0][NUM_CPU-1:0]    routeWords,
  output strobe_t                            str
);
  localparam logic [NUM_W-1:0] SRC_LIM = NUM_W'(NUM_SRC);
  localparam logic [CPU_W:0]   CPU_LIM = (CPU_W+1)'(NUM_CPU);

  logic              gWr;
  logic              lWr;
  logic [ADDR_W-1:0] routeOff;
  logic [NUM_W-1:0]  routeIdx;
  logic              routeHit;
  logic              cpuOk;

  assign gWr      = busWrite && !busLocal;
  assign lWr      = busWrite && busLocal;
  assign routeOff = busAddr - OFF_ROUTE;
  assign routeIdx = routeOff[ADDR_W-1:2];
  assign routeHit = (busAddr >= OFF_ROUTE) && (busAddr[1:0] == 2'b00)
                    && (routeIdx < SRC_LIM);
  assign cpuOk    = {1'b0, busCpu} < CPU_LIM;

  always_comb begin
    str          = '0;
    str.enSet    = gWr && (busAddr == OFF_EN_SET);
    str.enClr    = gWr && (busAddr == OFF_EN_CLR);
    str.routeWr  = gWr && routeHit;
    str.maskSet  = lWr && cpuOk && (busAddr == OFF_MSK_SET);
    str.maskClr  = lWr && cpuOk && (busAddr == OFF_MSK_CLR);
    str.idx      = str.routeWr ? routeIdx : busWdata[NUM_W-1:0];
    str.cpu      = 4'(busCpu);
    str.routeVal = busWdata[15:0];
  end

  always_comb begin
    busRdata = '0;
    if (!busLocal) begin
      if (busAddr == OFF_CTRL)
        busRdata[11:2] = SRC_LIM;
      else if (routeHit)
        busRdata[NUM_CPU-1:0] = routeWords[routeIdx[SRC_W-1:0]];
    end else if (cpuOk && busAddr == OFF_ACK) begin
      busRdata[NUM_W-1:0] = ackNum[busCpu];
    end
  end

  logic unusedWdata;
  assign unusedWdata = ^busWdata[DATA_W-1:16];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.enSet, str.enClr, str.maskSet, str.maskClr, str.routeWr})); // R2
endmodule

// File: rtl/mpic_datapath.sv
module mpic_datapath
  import mpic_pkg::*;
#(
  parameter int NUM_CPU  = 2,
  parameter int NUM_SRC  = 16,
  parameter int PRIV_SRC = 5,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         str,
  input  logic [NUM_SRC-1:0]              srcLevel,
  input  logic [NUM_CPU-1:0]              privLevel,
  input  logic [NUM_CPU-1:0]              dbellLevel,
  output logic [NUM_CPU-1:0][NUM_W-1:0]   ackNum,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0] routeWords,
  output logic [NUM_CPU-1:0]              irqOut
);
  localparam logic [NUM_W-1:0] SRC_LIM = NUM_W'(NUM_SRC);

  logic [NUM_SRC-1:0]              globEn;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] cpuMask;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;

  logic             idxOk;
  logic [SRC_W-1:0] idxS;
  logic [3:0]       cpuS;

  assign idxOk = str.idx < SRC_LIM;
  assign idxS  = str.idx[SRC_W-1:0];
  assign cpuS  = str.cpu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globEn  <= '0;
      route   <= '0;
      cpuMask <= '1;
    end else if (idxOk) begin
      if (str.enSet)   globEn[idxS] <= 1'b1;
      if (str.enClr)   globEn[idxS] <= 1'b0;
      if (str.routeWr) route[idxS]  <= str.routeVal[NUM_CPU-1:0];
      if (str.maskSet) cpuMask[cpuS[$clog2(NUM_CPU)-1:0]][idxS] <= 1'b1;
      if (str.maskClr) cpuMask[cpuS[$clog2(NUM_CPU)-1:0]][idxS] <= 1'b0;
    end
  end

  assign routeWords = route;

  // Pending matrix: doorbell, private timer, or routed shared source
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s == 0) begin : g_dbell
        assign pend[c][s] = dbellLevel[c] & ~cpuMask[c][s];
      end else if (s == PRIV_SRC) begin : g_priv
        assign pend[c][s] = privLevel[c] & globEn[s] & ~cpuMask[c][s];
      end else begin : g_shared
        assign pend[c][s] = srcLevel[s] & globEn[s] & route[s][c] & ~cpuMask[c][s];
      end
    end

    always_comb begin
      ackNum[c] = ACK_NONE;
      for (int s = NUM_SRC - 1; s >= 0; s--)
        if (pend[c][s]) ackNum[c] = NUM_W'(s);
    end

    assign irqOut[c] = |pend[c];

    AST_IRQ_AGREES_ACK: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] == (ackNum[c] != ACK_NONE)); // R7
    AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      (ackNum[c] == ACK_NONE) || (ackNum[c] < SRC_LIM)); // R6
  end

  logic unusedStr;
  assign unusedStr = ^{str.routeVal, str.idx, str.cpu, srcLevel[0], srcLevel[PRIV_SRC]};

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (str.enSet && idxOk) |=> globEn[$past(idxS)]); // R2
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (str.enClr && idxOk) |=> !globEn[$past(idxS)]); // R2
  AST_BAD_IDX_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ((str.enSet || str.enClr) && !idxOk) |=> $stable(globEn)); // R2
  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&cpuMask && globEn == '0)); // R12
endmodule

// File: rtl/mpic_top.sv
module mpic_top
  import mpic_pkg::*;
#(
  parameter int NUM_CPU  = 2,
  parameter int NUM_SRC  = 16,
  parameter int PRIV_SRC = 5,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrite,
  input  logic               busLocal,
  input  logic [CPU_W-1:0]   busCpu,
  input  logic [11:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [NUM_CPU-1:0] privLevel,
  input  logic [NUM_CPU-1:0] dbellLevel,
  output logic [NUM_CPU-1:0] irqOut
);
  strobe_t                         str;
  logic [NUM_CPU-1:0][NUM_W-1:0]   ackNum;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] routeWords;

  mpic_ctrl #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busLocal(busLocal),
    .busCpu(busCpu), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .ackNum(ackNum), .routeWords(routeWords), .str(str)
  );

  mpic_datapath #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .PRIV_SRC(PRIV_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .srcLevel(srcLevel),
    .privLevel(privLevel), .dbellLevel(dbellLevel), .ackNum(ackNum),
    .routeWords(routeWords), .irqOut(irqOut)
  );
endmodule

// File: tb/mpic_top_bench.sv
`timescale 1ns/1ps
module mpic_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic        busLocal = 1'b0;
  logic [0:0]  busCpu = '0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] srcLevel = '0;
  logic [1:0]  privLevel = '0;
  logic [1:0]  dbellLevel = '0;
  logic [1:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mpic_top u_mpic_top (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busLocal(busLocal),
    .busCpu(busCpu), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .srcLevel(srcLevel), .privLevel(privLevel),
    .dbellLevel(dbellLevel), .irqOut(irqOut)
  );

  // {srcLevel, privLevel, dbellLevel, expected ack cpu0, expected ack cpu1}
  localparam logic [39:0] VEC [12] = '{
    {16'h0000, 2'b00, 2'b00, 10'd1023, 10'd1023},
    {16'h0008, 2'b00, 2'b00, 10'd3,    10'd1023},
    {16'h0080, 2'b00, 2'b00, 10'd1023, 10'd7},
    {16'h0200, 2'b00, 2'b00, 10'd9,    10'd9},
    {16'h0288, 2'b00, 2'b00, 10'd3,    10'd7},
    {16'h1200, 2'b00, 2'b00, 10'd9,    10'd9},
    {16'h0021, 2'b00, 2'b00, 10'd1023, 10'd1023},
    {16'h0000, 2'b01, 2'b00, 10'd5,    10'd1023},
    {16'h0008, 2'b10, 2'b00, 10'd3,    10'd5},
    {16'h0080, 2'b00, 2'b10, 10'd1023, 10'd0},
    {16'h0008, 2'b01, 2'b01, 10'd0,    10'd1023},
    {16'h0010, 2'b00, 2'b00, 10'd1023, 10'd1023}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic loc, input logic cpu, input logic [11:0] addr,
                    input logic [31:0] data);
    @(negedge clk);
    busLocal = loc; busCpu = cpu; busAddr = addr; busWdata = data; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic loc, input logic cpu, input logic [11:0] addr,
                    output logic [31:0] data);
    @(negedge clk);
    busLocal = loc; busCpu = cpu; busAddr = addr;
    #1 data = busRdata;
  endtask

  task automatic ackChk(input string req, input logic [9:0] e0, input logic [9:0] e1);
    logic [31:0] v;
    rd(1'b1, 1'b0, 12'h044, v); chk({req, " ack cpu0"}, v, {22'd0, e0});
    rd(1'b1, 1'b1, 12'h044, v); chk({req, " ack cpu1"}, v, {22'd0, e1});
    chk({req, " R7 irq"}, {30'd0, irqOut},
        {30'd0, (e1 != 10'd1023), (e0 != 10'd1023)});
  endtask

  task automatic setLevels(input logic [15:0] s, input logic [1:0] p, input logic [1:0] d);
    @(negedge clk);
    srcLevel = s; privLevel = p; dbellLevel = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    rd(1'b0, 1'b0, 12'h000, v); chk("R1 control word", v, 32'h0000_0040);
    rd(1'b0, 1'b0, 12'h124, v); chk("R12 routing after reset", v, 32'h0);
    setLevels(16'hFFFF, 2'b11, 2'b11);
    ackChk("R12 reset masks", 10'd1023, 10'd1023);
    setLevels(16'h0000, 2'b00, 2'b00);

    // Configuration: enable 1..15, route, unmask everything
    for (int s = 1; s < 16; s++) wr(1'b0, 1'b0, 12'h030, 32'(s));
    wr(1'b0, 1'b0, 12'h10C, 32'h1);            // src3 -> cpu0
    wr(1'b0, 1'b0, 12'h11C, 32'h2);            // src7 -> cpu1
    wr(1'b0, 1'b0, 12'h124, 32'hFFFF_FFF3);    // src9 -> both
    wr(1'b0, 1'b0, 12'h130, 32'h2);            // src12 -> cpu1
    wr(1'b0, 1'b0, 12'h114, 32'h3);            // src5 routing, ignored
    rd(1'b0, 1'b0, 12'h124, v); chk("R3 routing readback", v, 32'h3);
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 16; s++) wr(1'b1, 1'(c), 12'h04C, 32'(s));

    // Table walk (R5 R6 R8 R9 R11)
    for (int i = 0; i < 12; i++) begin
      setLevels(VEC[i][39:24], VEC[i][23:22], VEC[i][21:20]);
      ackChk($sformatf("R5 R6 R8 R9 R11 vector %0d", i), VEC[i][19:10], VEC[i][9:0]);
    end

    // R2: out-of-range index ignored, clear and set by number
    wr(1'b0, 1'b0, 12'h110, 32'h1);            // src4 -> cpu0
    setLevels(16'h0010, 2'b00, 2'b00);
    ackChk("R2 src4 enabled", 10'd4, 10'd1023);
    wr(1'b0, 1'b0, 12'h034, 32'd20);
    ackChk("R2 out-of-range clear ignored", 10'd4, 10'd1023);
    wr(1'b0, 1'b0, 12'h034, 32'd4);
    ackChk("R2 clear enable", 10'd1023, 10'd1023);
    wr(1'b0, 1'b0, 12'h030, 32'd4);
    ackChk("R2 set enable", 10'd4, 10'd1023);

    // R4: mask affects only the accessing CPU
    setLevels(16'h0200, 2'b00, 2'b00);
    wr(1'b1, 1'b0, 12'h048, 32'd9);
    ackChk("R4 mask cpu0 only", 10'd1023, 10'd9);
    wr(1'b1, 1'b0, 12'h04C, 32'd9);
    ackChk("R4 unmask cpu0", 10'd9, 10'd9);

    // R10: ack read does not clear, level drop does
    setLevels(16'h0008, 2'b00, 2'b00);
    rd(1'b1, 1'b0, 12'h044, v); chk("R10 first ack", v, 32'd3);
    rd(1'b1, 1'b0, 12'h044, v); chk("R10 repeated ack", v, 32'd3);
    setLevels(16'h0000, 2'b00, 2'b00);
    ackChk("R10 level dropped", 10'd1023, 10'd1023);

    // R9: private source needs enable 5; R8: doorbell gated by mask bit 0
    wr(1'b0, 1'b0, 12'h034, 32'd5);
    setLevels(16'h0000, 2'b01, 2'b00);
    ackChk("R9 private disabled", 10'd1023, 10'd1023);
    wr(1'b1, 1'b1, 12'h048, 32'd0);
    setLevels(16'h0000, 2'b00, 2'b11);
    ackChk("R8 doorbell mask", 10'd0, 10'd1023);

    // R6: upper bits zero on a non-empty ack
    setLevels(16'h0080, 2'b00, 2'b00);
    rd(1'b1, 1'b1, 12'h044, v); chk("R6 ack upper bits", v, 32'd7);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule